// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a nanosecond time-of-day count that moves forward by a programmable step on every cycle of its reference clock. The count rate can be trimmed without changing the step. A trim interval N is programmed, and on every Nth enabled cycle the counter adds a second programmed step, called the correction step, in place of the normal one. Over a long window this shifts the average rate by a fraction that software chooses.

The counter wraps in one of two ways. It can wrap at a programmed period, for example 2^31 to get a 31-bit time base. When that mode is off, it rolls over at its full width. A one-cycle wrap pulse marks each wrap at the period so that compare channels downstream can re-arm. Software can load the counter directly through a register write. It can also request a snapshot, which freezes the live count into a readable register so that a multi-word read stays coherent. The live count is also driven out as a port for compare logic.

The register port has a write strobe with an address and data, and a read address with a registered read-data output.

Top module: `adj_ns_counter`

## Requirements
- R1: While the synchronous active-high reset is asserted, the counter goes to 0, the wrap pulse goes low, the read data goes to 0 and every register clears. The bench checks this after reset is released.
- R2: Register map: address 0 is control, with bit 0 = run, bit 1 = period-wrap enable and bit 2 = snapshot request. Address 1 is the count. Address 2 is the step, with the normal step in bits 6:0 and the correction step in bits 14:8. Address 3 is the trim interval N. Address 4 is the wrap period. Each enabled cycle adds the normal step to the counter. While run is 0 the counter holds its value.
- R3: When N is nonzero, every Nth enabled cycle adds the correction step in place of the normal one. After k enabled cycles the counter has gained floor(k/N) correction steps. A write to address 3 restarts the phase of the interval. N = 0 turns correction off.
- R4: When period-wrap is enabled and the period is nonzero, a step whose sum reaches or passes the period leaves the counter at sum minus period. This is 0 when the period is a multiple of the step.
- R5: When period-wrap is disabled or the period is 0, the counter wraps modulo 2^CNT_W, and the period register has no effect.
- R6: The wrap pulse is high for exactly the first cycle in which the counter holds a value that was wrapped at the period. It stays low on a full-width rollover.
- R7: A write to address 1 loads the written value into the counter at that clock edge. The load takes priority over that cycle's step.
- R8: Writing control with bit 2 set causes a snapshot. On the next edge the live count is copied into the snapshot register, which is read at address 1, and bit 2 clears at that same edge.
- R9: Read data is registered and appears one cycle after the read address is presented. The step register reads back only its implemented fields, so writing all ones reads back 0x7F7F. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 32 | Registered read data |
| time_ns | output | CNT_W (32) | Live counter value |
| wrap_pulse | output | 1 | One-cycle pulse on a wrap at the period |

## Verification
The trim tests use several step and interval pairs, including N = 1 and an interval count that divides the run exactly. An off-by-one in the phase counter would add one correction too many or too few and shift the final count by the difference between the two steps. One period test uses a step that does not divide the period. A design that clears to zero in place of subtracting the period would then lose the remainder. A separate test runs with wrap disabled and a period still programmed, which would catch a design that applies the period in that mode. The wrap pulse is sampled on the cycle before the wrap, on the wrap cycle and on the cycle after, and again on a full-width rollover where it must stay low. The load-priority check would show an extra step added on top of the loaded value. The snapshot check reads a value that the still-running counter has already moved past, and then confirms that the request bit has cleared.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam int STEP_W   = 7;
  localparam int CORR_LSB = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STEP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TRIM   = 3'd3;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd4;

  localparam int B_RUN  = 0;
  localparam int B_PRD  = 1;
  localparam int B_SNAP = 2;
endpackage

// File: rtl/ntc_regs.sv
module ntc_regs
  import ntc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              run_o,
  output logic              prd_en_o,
  output logic [STEP_W-1:0] step_norm_o,
  output logic [STEP_W-1:0] step_corr_o,
  output logic [TRIM_W-1:0] trim_n_o,
  output logic              trim_restart_o,
  output logic [CNT_W-1:0]  period_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  logic              run_q, prd_q, snap_req_q;
  logic [STEP_W-1:0] norm_q, corr_q;
  logic [TRIM_W-1:0] trim_q;
  logic [CNT_W-1:0]  period_q, snap_q;
  logic              wr_ctrl;

  assign wr_ctrl = we_i && (waddr_i == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; prd_q <= 1'b0; snap_req_q <= 1'b0;
      norm_q <= '0; corr_q <= '0; trim_q <= '0;
      period_q <= '0; snap_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q      <= wdata_i[B_RUN];
        prd_q      <= wdata_i[B_PRD];
        snap_req_q <= wdata_i[B_SNAP];
      end else if (snap_req_q) begin
        snap_q     <= cnt_i;
        snap_req_q <= 1'b0;
      end
      if (we_i && waddr_i == A_STEP) begin
        norm_q <= wdata_i[STEP_W-1:0];
        corr_q <= wdata_i[CORR_LSB +: STEP_W];
      end
      if (we_i && waddr_i == A_TRIM)   trim_q   <= wdata_i[TRIM_W-1:0];
      if (we_i && waddr_i == A_PERIOD) period_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (raddr_i)
        A_CTRL:   rdata_o <= DATA_W'({snap_req_q, prd_q, run_q});
        A_COUNT:  rdata_o <= DATA_W'(snap_q);
        A_STEP:   rdata_o <= DATA_W'({corr_q, {(CORR_LSB-STEP_W){1'b0}}, norm_q});
        A_TRIM:   rdata_o <= DATA_W'(trim_q);
        A_PERIOD: rdata_o <= DATA_W'(period_q);
        default:  rdata_o <= '0;
      endcase
    end
  end

  assign run_o          = run_q;
  assign prd_en_o       = prd_q;
  assign step_norm_o    = norm_q;
  assign step_corr_o    = corr_q;
  assign trim_n_o       = trim_q;
  assign trim_restart_o = we_i && (waddr_i == A_TRIM);
  assign period_o       = period_q;
  assign load_o         = we_i && (waddr_i == A_COUNT);
  assign load_val_o     = wdata_i[CNT_W-1:0];

  // R8: a pending snapshot request is consumed on the following edge
  assert_snap_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (snap_req_q && !wr_ctrl) |=> !snap_req_q);
endmodule

// File: rtl/ntc_trim.sv
module ntc_trim
  import ntc_pkg::*;
#(
  parameter int TRIM_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [TRIM_W-1:0] trim_n_i,
  input  logic [STEP_W-1:0] step_norm_i,
  input  logic [STEP_W-1:0] step_corr_i,
  output logic [STEP_W-1:0] step_o
);
  logic [TRIM_W-1:0] phase_q;
  logic              trim_on, use_corr;

  assign trim_on  = (trim_n_i != '0);
  assign use_corr = trim_on && (phase_q == trim_n_i - TRIM_W'(1));
  assign step_o   = use_corr ? step_corr_i : step_norm_i;

  always_ff @(posedge clk) begin
    if (rst || restart_i)     phase_q <= '0;
    else if (run_i && trim_on) phase_q <= use_corr ? '0 : phase_q + TRIM_W'(1);
  end

  // R3: the phase never leaves the programmed interval
  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (rst)
    trim_on |-> (phase_q < trim_n_i));
endmodule

// File: rtl/ntc_core.sv
module ntc_core
  import ntc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              prd_en_i,
  input  logic [CNT_W-1:0]  period_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              wrap_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic [SUM_W-1:0] sum, over;
  logic             prd_act;

  assign sum     = {1'b0, cnt_q} + SUM_W'(step_i);
  assign over    = sum - {1'b0, period_i};
  assign prd_act = prd_en_i && (period_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      wrap_q <= 1'b0;
    end else if (run_i) begin
      if (prd_act && sum >= {1'b0, period_i}) begin
        cnt_q  <= over[CNT_W-1:0];
        wrap_q <= 1'b1;
      end else begin
        cnt_q  <= sum[CNT_W-1:0];
        wrap_q <= 1'b0;
      end
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R2: no movement while stopped and not loaded
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !load_i) |=> (cnt_q == $past(cnt_q)));
  // R7: a load lands exactly
  assert_load_R7: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cnt_q == $past(load_val_i)));
  // R6: a wrap pulse only follows a running cycle with period wrap active
  assert_wrap_src_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap_q) |-> $past(run_i && prd_act));
endmodule

// File: rtl/adj_ns_counter.sv
module adj_ns_counter
  import ntc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int TRIM_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_we,
  input  logic [2:0]           reg_waddr,
  input  logic [31:0]          reg_wdata,
  input  logic [2:0]           reg_raddr,
  output logic [31:0]          reg_rdata,
  output logic [CNT_W-1:0]     time_ns,
  output logic                 wrap_pulse
);
  logic              run, prd_en, restart, load;
  logic [STEP_W-1:0] norm, corr, step;
  logic [TRIM_W-1:0] trim_n;
  logic [CNT_W-1:0]  period, load_val, cnt;

  ntc_regs #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .waddr_i(reg_waddr),
    .wdata_i(reg_wdata), .raddr_i(reg_raddr), .rdata_o(reg_rdata),
    .cnt_i(cnt), .run_o(run), .prd_en_o(prd_en), .step_norm_o(norm),
    .step_corr_o(corr), .trim_n_o(trim_n), .trim_restart_o(restart),
    .period_o(period), .load_o(load), .load_val_o(load_val));

  ntc_trim #(.TRIM_W(TRIM_W)) u_trim (
    .clk(clk), .rst(rst), .run_i(run), .restart_i(restart),
    .trim_n_i(trim_n), .step_norm_i(norm), .step_corr_i(corr),
    .step_o(step));

  ntc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .run_i(run), .prd_en_i(prd_en),
    .period_i(period), .step_i(step), .load_i(load),
    .load_val_i(load_val), .cnt_o(cnt), .wrap_o(wrap_pulse));

  assign time_ns = cnt;
endmodule

// File: tb/sim_adj_ns_counter.sv
module sim_adj_ns_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic [31:0] time_ns;
  logic        wrap_pulse;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adj_ns_counter u0 (.clk(clk), .rst(rst), .reg_we(reg_we),
    .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
    .reg_rdata(reg_rdata), .time_ns(time_ns), .wrap_pulse(wrap_pulse));

  typedef struct packed {
    int unsigned step, corr, trim, period, prst, cyc, expv;
  } vec_t;
  localparam vec_t VEC [8] = '{
    '{8, 0, 0, 0,   0, 10, 80},   // R2 plain step
    '{8, 9, 4, 0,   0, 10, 82},   // R3 two corrections
    '{8, 7, 3, 0,   0,  9, 69},   // R3 interval divides run
    '{5, 6, 1, 0,   0,  4, 24},   // R3 every cycle corrected
    '{10,0, 0, 100, 1, 25, 50},   // R4 aligned period
    '{3, 0, 0, 10,  1,  7, 1},    // R4 remainder kept
    '{10,0, 0, 100, 0, 25, 250},  // R5 period ignored
    '{4, 0, 0, 0,   1,  6, 24}    // R5 period zero frees
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_raddr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  initial begin
    logic [31:0] r, v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 count", time_ns, 0);
    check("R1 wrap", {31'b0, wrap_pulse}, 0);
    rd(3'd0, r); check("R1 ctrl", r, 0);
    rd(3'd2, r); check("R1 step", r, 0);

    for (int i = 0; i < 8; i++) begin
      wr(3'd0, 0);
      wr(3'd2, (VEC[i].corr << 8) | VEC[i].step);
      wr(3'd3, VEC[i].trim);
      wr(3'd4, VEC[i].period);
      wr(3'd1, 0);
      wr(3'd0, 1 | (VEC[i].prst << 1));
      repeat (VEC[i].cyc) @(negedge clk);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), time_ns, VEC[i].expv);
    end

    wr(3'd0, 0);
    v = time_ns;
    repeat (5) @(negedge clk);
    check("R2 hold while stopped", time_ns, v);

    wr(3'd2, 8); wr(3'd3, 0); wr(3'd4, 0);
    wr(3'd1, 32'hFFFF_FFF8); wr(3'd0, 1);
    @(negedge clk);
    check("R5 rollover value", time_ns, 0);
    check("R6 no pulse on rollover", {31'b0, wrap_pulse}, 0);
    @(negedge clk);
    check("R5 after rollover", time_ns, 8);

    wr(3'd0, 0); wr(3'd2, 10); wr(3'd4, 100); wr(3'd1, 0); wr(3'd0, 3);
    repeat (9) @(negedge clk);
    check("R6 before wrap count", time_ns, 90);
    check("R6 before wrap pulse", {31'b0, wrap_pulse}, 0);
    @(negedge clk);
    check("R6 wrap count", time_ns, 0);
    check("R6 wrap pulse", {31'b0, wrap_pulse}, 1);
    @(negedge clk);
    check("R6 pulse one cycle", {31'b0, wrap_pulse}, 0);

    wr(3'd1, 55);
    check("R7 load priority", time_ns, 55);

    wr(3'd0, 7);
    v = time_ns;
    rd(3'd1, r); check("R8 snapshot value", r, v);
    rd(3'd0, r); check("R8 request cleared", r, 3);

    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, r); check("R9 step fields", r, 32'h0000_7F7F);
    rd(3'd4, r); check("R9 period readback", r, 100);
    rd(3'd7, r); check("R9 unmapped", r, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule